// File: doc/BRIEF.md
# Inter-VM Doorbell Register File

This block is the small register window of a shared-memory device that lets guests on one host signal each other. Software sees four 32-bit words: an interrupt enable mask, an interrupt cause word, a read-only word carrying this guest's own peer number, and a write-only doorbell. Writing the doorbell names a target peer and one of that peer's interrupt vectors. The block checks both against a live table of how many vectors each peer has registered. A ring that passes the check produces a single-cycle notification carrying the peer and vector. A ring that fails is dropped without any trace.

In the other direction, an incoming notification input loads the cause word with the value 1, unless the device runs in message-signalled mode. A level interrupt output is high while any cause bit is enabled by the mask. Reading the cause word hands back its value and empties it in the same access. The table of per-peer vector counts is loaded through a separate configuration port. The number of peers currently connected is a live input.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset the mask and cause words both read 0, `irq` is low and `ring_valid` is low. The vector-count table is all zero.
- R2: A write to word 0 stores all 32 data bits as the mask. On writes the byte address is reduced with 0xFC, so addresses 1 to 3 also reach the mask. A read at byte address 0 returns the mask.
- R3: A read at byte address 4 returns the cause word and clears it to 0 at the end of that access.
- R4: A write to word 3 is a doorbell with the target peer in data bits 31:16 and the vector in bits 7:0. Bits 15:8 have no effect. A valid ring raises `ring_valid` for exactly the one cycle after the write, with `ring_peer` and `ring_vec` set to the peer and vector.
- R5: A doorbell is dropped, with no pulse, when its peer is not below `peer_limit`, or when the peer is not below the table size MAX_PEERS.
- R6: A doorbell is dropped when its vector is not below the count held for its peer. Counts are loaded through `cfg_we`/`cfg_peer`/`cfg_count` and take effect from the next cycle.
- R7: A read at byte address 8 returns `own_pos` zero-extended. Reads at byte address 12, at any other offset, or at any address with nonzero low two bits return 0.
- R8: A `notify_in` pulse with `msg_mode` low loads the cause word with the value 1 on the next edge. With `msg_mode` high it leaves the cause word unchanged.
- R9: `irq` is high exactly when the stored cause word ANDed with the stored mask is nonzero.
- R10: When a cause read and a notification fall in the same cycle, the read returns the old value and the cause word ends up holding 1.
- R11: A write to word 1 loads the cause word with any 32-bit value, unless a notification arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address in the 256-byte window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational during the access |
| own_pos | input | 16 | This guest's own peer number |
| peer_limit | input | 16 | Number of peers currently connected |
| msg_mode | input | 1 | 1 = message-signalled mode, notifications bypass the cause word |
| notify_in | input | 1 | Incoming notification strobe |
| cfg_we | input | 1 | Vector-count table write strobe |
| cfg_peer | input | PIDX_W | Table entry to write |
| cfg_count | input | CNT_W | Vector count for that peer |
| ring_valid | output | 1 | One-cycle notification to a peer |
| ring_peer | output | 16 | Target peer of the notification |
| ring_vec | output | 8 | Target vector of the notification |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with MAX_PEERS = 4 and MAX_VEC = 5. The table is therefore small enough to fill entirely, and its entries can hold both zero and the largest count. With only four entries, `peer_limit` can be set above the table size, so the two drop conditions on the peer number are reached separately. Because the counts are small, a vector equal to a count, a vector one below it, and a peer with no vectors at all can all be rung with a few doorbells.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam logic [5:0] W_MASK = 6'd0;
  localparam logic [5:0] W_CAUSE = 6'd1;
  localparam logic [5:0] W_POS = 6'd2;
  localparam logic [5:0] W_BELL = 6'd3;

  // Write decode: byte address with the low two bits dropped
  function automatic logic [5:0] word_of(input logic [7:0] byte_addr);
    return byte_addr[7:2];
  endfunction

  // Read decode: only aligned addresses hit
  function automatic logic read_hit(input logic [7:0] byte_addr, input logic [5:0] word);
    return (byte_addr[1:0] == 2'b00) && (byte_addr[7:2] == word);
  endfunction

  function automatic logic below(input logic [15:0] v, input logic [15:0] lim);
    return v < lim;
  endfunction
endpackage

// File: rtl/pdb_vec_table.sv
module pdb_vec_table #(
  parameter int MAX_PEERS = 8,
  parameter int PIDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PIDX_W-1:0] cfg_peer,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [PIDX_W-1:0] look_peer,
  output logic [CNT_W-1:0]  look_count
);
  logic [CNT_W-1:0] cnt_q [MAX_PEERS];

  for (genvar p = 0; p < MAX_PEERS; p++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[p] <= '0;
      else if (cfg_we && (32'(cfg_peer) == p)) cnt_q[p] <= cfg_count;
    end
  end

  always_comb begin
    look_count = '0;
    for (int p = 0; p < MAX_PEERS; p++)
      if (32'(look_peer) == p) look_count = cnt_q[p];
  end
endmodule

// File: rtl/pdb_ring_check.sv
module pdb_ring_check
  import pdb_pkg::*;
#(
  parameter int MAX_PEERS = 8,
  parameter int PIDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bell_we,
  input  logic [31:0]       bell_word,
  input  logic [15:0]       peer_limit,
  output logic [PIDX_W-1:0] look_peer,
  input  logic [CNT_W-1:0]  look_count,
  output logic              bell_ok,
  output logic              ring_valid,
  output logic [15:0]       ring_peer,
  output logic [7:0]        ring_vec
);
  logic [15:0] dest;
  logic [7:0]  vec;
  logic [7:0]  unused_mid;

  assign dest = bell_word[31:16];
  assign vec = bell_word[7:0];
  assign unused_mid = bell_word[15:8];
  assign look_peer = dest[PIDX_W-1:0];

  assign bell_ok = below(dest, peer_limit)
                && below(dest, 16'(MAX_PEERS))
                && below(16'(vec), 16'(look_count));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_valid <= 1'b0;
      ring_peer <= '0;
      ring_vec <= '0;
    end else begin
      ring_valid <= bell_we && bell_ok;
      if (bell_we && bell_ok) begin
        ring_peer <= dest;
        ring_vec <= vec;
      end
    end
  end
endmodule

// File: rtl/pdb_ctrl_regs.sv
module pdb_ctrl_regs
  import pdb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_mask,
  input  logic        wr_cause,
  input  logic        rd_cause,
  input  logic        set_cause,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  input  logic [7:0]  rd_addr,
  input  logic [15:0] own_pos,
  output logic [31:0] rdata,
  output logic [31:0] mask_q,
  output logic [31:0] cause_q,
  output logic        irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_mask) mask_q <= wdata;
  end

  // Notification has priority over a software write or a read-clear
  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else if (set_cause) cause_q <= 32'd1;
    else if (wr_cause) cause_q <= wdata;
    else if (rd_cause) cause_q <= '0;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (read_hit(rd_addr, W_MASK)) rdata = mask_q;
      else if (read_hit(rd_addr, W_CAUSE)) rdata = cause_q;
      else if (read_hit(rd_addr, W_POS)) rdata = 32'(own_pos);
    end
  end

  assign irq = |(cause_q & mask_q);
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
  import pdb_pkg::*;
#(
  parameter int MAX_PEERS = 8,
  parameter int MAX_VEC = 4,
  localparam int PIDX_W = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1,
  localparam int CNT_W = $clog2(MAX_VEC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [7:0]        acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic [15:0]       own_pos,
  input  logic [15:0]       peer_limit,
  input  logic              msg_mode,
  input  logic              notify_in,
  input  logic              cfg_we,
  input  logic [PIDX_W-1:0] cfg_peer,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              ring_valid,
  output logic [15:0]       ring_peer,
  output logic [7:0]        ring_vec,
  output logic              irq
);
  logic              wr_en, rd_en;
  logic              wr_mask, wr_cause, rd_cause, set_cause, wr_bell, bell_ok;
  logic [PIDX_W-1:0] look_peer;
  logic [CNT_W-1:0]  look_count;
  logic [31:0]       mask_q, cause_q;

  assign wr_en = acc_valid && acc_write;
  assign rd_en = acc_valid && !acc_write;
  assign wr_mask = wr_en && (word_of(acc_addr) == W_MASK);
  assign wr_cause = wr_en && (word_of(acc_addr) == W_CAUSE);
  assign wr_bell = wr_en && (word_of(acc_addr) == W_BELL);
  assign rd_cause = rd_en && read_hit(acc_addr, W_CAUSE);
  assign set_cause = notify_in && !msg_mode;

  pdb_vec_table #(.MAX_PEERS(MAX_PEERS), .PIDX_W(PIDX_W), .CNT_W(CNT_W)) table_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_peer(cfg_peer),
    .cfg_count(cfg_count), .look_peer(look_peer), .look_count(look_count)
  );

  pdb_ring_check #(.MAX_PEERS(MAX_PEERS), .PIDX_W(PIDX_W), .CNT_W(CNT_W)) ring_i (
    .clk(clk), .rst_n(rst_n), .bell_we(wr_bell), .bell_word(acc_wdata),
    .peer_limit(peer_limit), .look_peer(look_peer), .look_count(look_count),
    .bell_ok(bell_ok), .ring_valid(ring_valid), .ring_peer(ring_peer),
    .ring_vec(ring_vec)
  );

  pdb_ctrl_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wr_cause(wr_cause),
    .rd_cause(rd_cause), .set_cause(set_cause), .wdata(acc_wdata),
    .rd_en(rd_en), .rd_addr(acc_addr), .own_pos(own_pos), .rdata(acc_rdata),
    .mask_q(mask_q), .cause_q(cause_q), .irq(irq)
  );
endmodule

// File: rtl/pdb_checker.sv
module pdb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_mask,
  input logic        wr_cause,
  input logic        rd_cause,
  input logic        set_cause,
  input logic        wr_bell,
  input logic        bell_ok,
  input logic [31:0] wdata,
  input logic [31:0] mask_q,
  input logic [31:0] cause_q,
  input logic        ring_valid,
  input logic        irq
);
  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_mask) |-> mask_q == $past(wdata));

  assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_cause && !set_cause && !wr_cause) |-> cause_q == 32'd0);

  assert_ring_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ring_valid |-> $past(wr_bell && bell_ok));

  assert_bad_bell_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_bell && !bell_ok) |-> !ring_valid);

  assert_notify_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_cause) |-> cause_q == 32'd1);

  assert_irq_after_notify_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_cause) && mask_q[0]) |-> irq);

  assert_cause_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_cause && !set_cause) |-> cause_q == $past(wdata));
endmodule

bind peer_doorbell_regs pdb_checker chk_i (
  .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wr_cause(wr_cause),
  .rd_cause(rd_cause), .set_cause(set_cause), .wr_bell(wr_bell),
  .bell_ok(bell_ok), .wdata(acc_wdata), .mask_q(mask_q), .cause_q(cause_q),
  .ring_valid(ring_valid), .irq(irq)
);

// File: tb/peer_doorbell_regs_tb_top.sv
module peer_doorbell_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NV = 5;
  localparam int PW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [15:0] own_pos = 16'h0002, peer_limit = 16'd3;
  logic msg_mode = 1'b0, notify_in = 1'b0;
  logic cfg_we = 1'b0;
  logic [PW-1:0] cfg_peer = '0;
  logic [CW-1:0] cfg_count = '0;
  logic ring_valid;
  logic [15:0] ring_peer;
  logic [7:0] ring_vec;
  logic irq;

  int total = 0, bad = 0;

  // reference model state
  logic [31:0] m_mask = 0, m_cause = 0;
  int m_cnt[NP];
  bit m_ring = 0;
  int m_rpeer = 0, m_rvec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  peer_doorbell_regs #(.MAX_PEERS(NP), .MAX_VEC(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .own_pos(own_pos), .peer_limit(peer_limit), .msg_mode(msg_mode),
    .notify_in(notify_in), .cfg_we(cfg_we), .cfg_peer(cfg_peer),
    .cfg_count(cfg_count), .ring_valid(ring_valid), .ring_peer(ring_peer),
    .ring_vec(ring_vec), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h want %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'd0) return m_mask;
    if (a == 8'd4) return m_cause;
    if (a == 8'd8) return {16'd0, own_pos};
    return 32'd0;
  endfunction

  // one clock cycle with the currently driven inputs
  task automatic cyc(input string tag);
    logic [31:0] nm, nc;
    bit nr;
    int np, nv, dst, vc;
    #1;
    if (acc_valid && !acc_write) chk(tag, acc_rdata, model_read(acc_addr));
    nm = m_mask; nc = m_cause; nr = 0; np = m_rpeer; nv = m_rvec;
    if (acc_valid && acc_write) begin
      case (acc_addr >> 2)
        0: nm = acc_wdata;
        1: nc = acc_wdata;
        3: begin
          dst = int'(acc_wdata >> 16);
          vc = int'(acc_wdata & 32'hFF);
          if (dst < int'(peer_limit) && dst < NP && vc < m_cnt[dst]) begin
            nr = 1; np = dst; nv = vc;
          end
        end
        default: ;
      endcase
    end
    if (acc_valid && !acc_write && acc_addr == 8'd4 && !(acc_valid && acc_write)) nc = 0;
    if (notify_in && !msg_mode) nc = 1;
    @(posedge clk);
    if (!rst_n) begin
      nm = 0; nc = 0; nr = 0; np = 0; nv = 0;
      for (int i = 0; i < NP; i++) m_cnt[i] = 0;
    end else if (cfg_we) m_cnt[cfg_peer] = int'(cfg_count);
    m_mask = nm; m_cause = nc; m_ring = nr; m_rpeer = np; m_rvec = nv;
    @(negedge clk);
    chk({tag, " R9 irq"}, {31'd0, irq}, {31'd0, (m_mask & m_cause) != 0});
    chk({tag, " R4/R5 ring_valid"}, {31'd0, ring_valid}, {31'd0, m_ring});
    if (m_ring) begin
      chk({tag, " R4 ring_peer"}, {16'd0, ring_peer}, 32'(m_rpeer));
      chk({tag, " R4 ring_vec"}, {24'd0, ring_vec}, 32'(m_rvec));
    end
    acc_valid = 0; acc_write = 0; acc_addr = 0; acc_wdata = 0;
    notify_in = 0; cfg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    acc_valid = 1; acc_write = 0; acc_addr = a; cyc(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d; cyc(tag);
  endtask

  task automatic bell(input int dst, input int vc, input logic [7:0] mid, input string tag);
    wr(8'd12, {dst[15:0], mid, vc[7:0]}, tag);
  endtask

  task automatic setcnt(input int p, input int c);
    cfg_we = 1; cfg_peer = p[PW-1:0]; cfg_count = c[CW-1:0]; cyc("R6 cfg");
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc("R1 reset");
    cyc("R1 reset");
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: got hang want finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) m_cnt[i] = 0;
    @(negedge clk);
    do_reset();
    // R1: reset values
    rd(8'd0, "R1 mask after reset");
    rd(8'd4, "R1 cause after reset");
    bell(0, 0, 8'h00, "R1 empty table drops");
    // R2: mask write and readback, low address bits on write
    wr(8'd0, 32'hA5A5_0001, "R2 mask write");
    rd(8'd0, "R2 mask readback");
    wr(8'd2, 32'h0000_0003, "R2 masked address write");
    rd(8'd0, "R2 masked address readback");
    // R7: position and zero reads
    rd(8'd8, "R7 own position");
    rd(8'd12, "R7 doorbell reads zero");
    rd(8'h40, "R7 unmapped reads zero");
    rd(8'h05, "R7 unaligned read zero");
    // R6: load counts
    setcnt(0, 2); setcnt(1, 0); setcnt(2, 5); setcnt(3, 1);
    // R4 valid with bits 15:8 set
    bell(2, 4, 8'hFF, "R4 valid ring top vector");
    bell(2, 5, 8'h00, "R6 vector equal to count");
    bell(1, 0, 8'h00, "R6 peer with no vectors");
    bell(3, 0, 8'h00, "R5 peer at limit");
    peer_limit = 16'd10;
    bell(3, 0, 8'h12, "R5 peer below raised limit");
    bell(5, 0, 8'h00, "R5 peer beyond table");
    bell(0, 1, 8'h00, "R4 back-to-back first");
    bell(0, 0, 8'h00, "R4 back-to-back second");
    setcnt(0, 0);
    bell(0, 0, 8'h00, "R6 count lowered live");
    // R11 / R3
    wr(8'd4, 32'h0000_00F0, "R11 cause write");
    rd(8'd4, "R3 cause read value");
    rd(8'd4, "R3 cause cleared");
    wr(8'd4, 32'hFFFF_FFFF, "R11 cause write all ones");
    rd(8'd4, "R11 cause all ones readback");
    // R8 / R9
    notify_in = 1; cyc("R8 notify sets cause");
    rd(8'd4, "R8 cause holds one");
    notify_in = 1; cyc("R8 notify again");
    wr(8'd0, 32'd0, "R9 mask off");
    wr(8'd0, 32'd1, "R9 mask on");
    msg_mode = 1;
    wr(8'd4, 32'h0000_0002, "R11 cause write two");
    notify_in = 1; cyc("R8 message mode notify ignored");
    rd(8'd4, "R8 message mode cause unchanged");
    msg_mode = 0;
    // R10: read-clear and notify in the same cycle
    wr(8'd4, 32'h0000_0008, "R11 cause write eight");
    acc_valid = 1; acc_write = 0; acc_addr = 8'd4; notify_in = 1;
    cyc("R10 read returns old value");
    rd(8'd4, "R10 notify wins over clear");
    // notify beats software write
    acc_valid = 1; acc_write = 1; acc_addr = 8'd4; acc_wdata = 32'h77; notify_in = 1;
    cyc("R11 notify beats write");
    rd(8'd4, "R11 cause after collision");
    // R1: second reset clears everything
    wr(8'd0, 32'hFFFF_FFFF, "R2 mask all ones");
    notify_in = 1; cyc("R8 notify before reset");
    do_reset();
    rd(8'd0, "R1 mask after second reset");
    rd(8'd4, "R1 cause after second reset");
    bell(2, 0, 8'h00, "R1 table cleared by reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule